// File: doc/BRIEF.md
# Debug Register Access Trap Arbiter

This block decides what happens when an instruction tries to read or write a protected debug system register. It looks at the current exception level, which higher levels exist and are enabled, whether each of levels 2 and 3 runs in the 32-bit or the 64-bit execution state, the debug-access and debug-exception trap controls at those levels, and two secure-debug-undefined conditions. From these it picks exactly one outcome: permit the access, make it undefined, trap it to level 2 by the 64-bit route, trap it to level 2 by the 32-bit hypervisor route, or trap it to level 3.

The checks run in a fixed priority order. A level-1 access is tested first against the high-priority secure undefined condition, then against the level-2 controls, then against the level-3 trap. A level-2 access skips the level-2 controls. Every trap outcome also reports the syndrome exception class. The decision is combinational. A parameter adds one output register stage, which is on by default.

Top module: `dbg_trap_arbiter`

## Requirements
- R1: An access from level 0 (`el_i` = 0) always gives undefined.
- R2: An access from level 3 (`el_i` = 3) is always permitted, whatever the trap controls say.
- R3: At level 1 or 2, the result is undefined ahead of every other check when all of these hold: level 3 is present, level 3 is in 64-bit state, the level-3 access trap is set, and `sdd_undef_prio_i` is high.
- R4: At level 1, level 2 counts as enabled only when both `el2_present_i` and `el2_enable_i` are high. If level 2 is enabled and in 64-bit state, and either its access trap or its exception trap is set, the access traps to level 2 by the 64-bit route. This check comes after R3 and before R5 and R6.
- R5: At level 1, if level 2 is enabled and in 32-bit state, and either of its trap controls is set, the access takes the hypervisor route. This check comes before R6.
- R6: At level 1 or 2, when no earlier check fires and level 3 is present, in 64-bit state and has its access trap set, the result is undefined if `sdd_undef_i` is high and a trap to level 3 otherwise. When no check fires at all, the access is permitted.
- R7: At level 2, the level-2 trap controls, the level-2 presence, enable and state inputs have no effect on the result.
- R8: `syndrome_o` is 0x05 whenever the result is one of the three traps, and 0 otherwise.
- R9: `result_o` has exactly one bit set, encoded as bit 0 permit, bit 1 undefined, bit 2 level-2 trap by the 64-bit route, bit 3 hypervisor trap, and bit 4 level-3 trap.
- R10: With `REG_OUT` = 1, the outputs show the decision for the inputs sampled at the previous rising clock edge. While reset is held they read undefined (`result_o` = 5'b00010) with `syndrome_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| el_i | input | 2 | Current exception level, 0 to 3 |
| el2_present_i | input | 1 | Level 2 is implemented |
| el3_present_i | input | 1 | Level 3 is implemented |
| el2_enable_i | input | 1 | Level 2 is enabled in the current security state |
| el2_aa64_i | input | 1 | Level 2 runs in 64-bit state |
| el3_aa64_i | input | 1 | Level 3 runs in 64-bit state |
| el2_trap_acc_i | input | 1 | Level-2 debug access trap control |
| el2_trap_exc_i | input | 1 | Level-2 debug exception routing trap control |
| el3_trap_acc_i | input | 1 | Level-3 debug access trap control |
| sdd_undef_prio_i | input | 1 | Secure debug undefined takes priority over level-2 traps |
| sdd_undef_i | input | 1 | Level-3 debug trap becomes undefined |
| result_o | output | 5 | One-hot access outcome |
| syndrome_o | output | 6 | Exception class reported on a trap |

## Verification
If the internal priority order is wrong, a particular input corner gets the wrong result bit or the wrong syndrome. This shows up as soon as that corner reaches the outputs: on the same cycle when there is no output register, or one clock later when there is. Because the block holds no state apart from the output register, a fault cannot build up over time. Covering every input combination therefore exposes every misrouting, including the cases where the high-priority undefined must override a level-2 trap and where level-2 controls must be ignored at level 2.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;
  localparam int LVL_W = 2;
  localparam int RES_W = 5;
  localparam int SYN_W = 6;

  localparam int IDX_PERMIT  = 0;
  localparam int IDX_UNDEF   = 1;
  localparam int IDX_T2_A64  = 2;
  localparam int IDX_T2_HYP  = 3;
  localparam int IDX_T3      = 4;

  typedef enum logic [LVL_W-1:0] {
    LVL_0 = 2'd0,
    LVL_1 = 2'd1,
    LVL_2 = 2'd2,
    LVL_3 = 2'd3
  } level_e;
endpackage

// File: rtl/dbg_trap_l3_check.sv
module dbg_trap_l3_check (
  input  logic present_i,
  input  logic aa64_i,
  input  logic trap_acc_i,
  input  logic undef_prio_i,
  input  logic sdd_undef_i,
  output logic prio_undef_o,
  output logic late_undef_o,
  output logic late_trap_o
);
  logic armed;

  // trap only meaningful when the monitor level runs 64-bit
  assign armed        = present_i & aa64_i & trap_acc_i;
  assign prio_undef_o = armed & undef_prio_i;
  assign late_undef_o = armed & sdd_undef_i;
  assign late_trap_o  = armed & ~sdd_undef_i;
endmodule

// File: rtl/dbg_trap_l2_check.sv
module dbg_trap_l2_check (
  input  logic present_i,
  input  logic enable_i,
  input  logic aa64_i,
  input  logic trap_acc_i,
  input  logic trap_exc_i,
  output logic a64_trap_o,
  output logic hyp_trap_o
);
  logic active;

  assign active     = present_i & enable_i & (trap_acc_i | trap_exc_i);
  assign a64_trap_o = active & aa64_i;
  assign hyp_trap_o = active & ~aa64_i;
endmodule

// File: rtl/dbg_trap_prio.sv
module dbg_trap_prio
  import dbg_trap_pkg::*;
#(
  parameter logic [SYN_W-1:0] TRAP_EC = 6'h05
) (
  input  level_e           lvl_i,
  input  logic             prio_undef_i,
  input  logic             l2_a64_i,
  input  logic             l2_hyp_i,
  input  logic             late_undef_i,
  input  logic             late_trap_i,
  output logic [RES_W-1:0] res_o,
  output logic [SYN_W-1:0] syn_o
);
  logic is_trap;

  always_comb begin
    res_o = '0;
    unique case (lvl_i)
      LVL_0: res_o[IDX_UNDEF] = 1'b1;
      LVL_1: begin
        if (prio_undef_i)      res_o[IDX_UNDEF]  = 1'b1;
        else if (l2_a64_i)     res_o[IDX_T2_A64] = 1'b1;
        else if (l2_hyp_i)     res_o[IDX_T2_HYP] = 1'b1;
        else if (late_undef_i) res_o[IDX_UNDEF]  = 1'b1;
        else if (late_trap_i)  res_o[IDX_T3]     = 1'b1;
        else                   res_o[IDX_PERMIT] = 1'b1;
      end
      LVL_2: begin
        if (prio_undef_i)      res_o[IDX_UNDEF]  = 1'b1;
        else if (late_undef_i) res_o[IDX_UNDEF]  = 1'b1;
        else if (late_trap_i)  res_o[IDX_T3]     = 1'b1;
        else                   res_o[IDX_PERMIT] = 1'b1;
      end
      default: res_o[IDX_PERMIT] = 1'b1;
    endcase
  end

  assign is_trap = res_o[IDX_T2_A64] | res_o[IDX_T2_HYP] | res_o[IDX_T3];
  assign syn_o   = is_trap ? TRAP_EC : '0;
endmodule

// File: rtl/dbg_trap_arbiter.sv
module dbg_trap_arbiter
  import dbg_trap_pkg::*;
#(
  parameter bit                REG_OUT = 1'b1,
  parameter logic [SYN_W-1:0]  TRAP_EC = 6'h05
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] el_i,
  input  logic             el2_present_i,
  input  logic             el3_present_i,
  input  logic             el2_enable_i,
  input  logic             el2_aa64_i,
  input  logic             el3_aa64_i,
  input  logic             el2_trap_acc_i,
  input  logic             el2_trap_exc_i,
  input  logic             el3_trap_acc_i,
  input  logic             sdd_undef_prio_i,
  input  logic             sdd_undef_i,
  output logic [RES_W-1:0] result_o,
  output logic [SYN_W-1:0] syndrome_o
);
  localparam logic [RES_W-1:0] RES_RST = RES_W'(1) << IDX_UNDEF;

  logic             prio_undef, late_undef, late_trap;
  logic             l2_a64, l2_hyp;
  logic [RES_W-1:0] res_d;
  logic [SYN_W-1:0] syn_d;

  dbg_trap_l3_check u_l3 (
    .present_i   (el3_present_i),
    .aa64_i      (el3_aa64_i),
    .trap_acc_i  (el3_trap_acc_i),
    .undef_prio_i(sdd_undef_prio_i),
    .sdd_undef_i (sdd_undef_i),
    .prio_undef_o(prio_undef),
    .late_undef_o(late_undef),
    .late_trap_o (late_trap)
  );

  dbg_trap_l2_check u_l2 (
    .present_i (el2_present_i),
    .enable_i  (el2_enable_i),
    .aa64_i    (el2_aa64_i),
    .trap_acc_i(el2_trap_acc_i),
    .trap_exc_i(el2_trap_exc_i),
    .a64_trap_o(l2_a64),
    .hyp_trap_o(l2_hyp)
  );

  dbg_trap_prio #(.TRAP_EC(TRAP_EC)) u_prio (
    .lvl_i       (level_e'(el_i)),
    .prio_undef_i(prio_undef),
    .l2_a64_i    (l2_a64),
    .l2_hyp_i    (l2_hyp),
    .late_undef_i(late_undef),
    .late_trap_i (late_trap),
    .res_o       (res_d),
    .syn_o       (syn_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [RES_W-1:0] res_q;
      logic [SYN_W-1:0] syn_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          res_q <= RES_RST;
          syn_q <= '0;
        end else begin
          res_q <= res_d;
          syn_q <= syn_d;
        end
      end
      assign result_o   = res_q;
      assign syndrome_o = syn_q;

      assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (result_o == $past(res_d)) && (syndrome_o == $past(syn_d)));
    end else begin : g_comb
      assign result_o   = res_d;
      assign syndrome_o = syn_d;
    end
  endgenerate

  assert_el0_undef_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_i == 2'd0) |-> res_d[IDX_UNDEF]);
  assert_el3_permit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_i == 2'd3) |-> res_d[IDX_PERMIT]);
  assert_prio_undef_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_i inside {2'd1, 2'd2} && prio_undef) |-> res_d[IDX_UNDEF]);
  assert_el2_no_l2trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_i == 2'd2) |-> !res_d[IDX_T2_A64] && !res_d[IDX_T2_HYP]);
  assert_syndrome_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_d[IDX_PERMIT] || res_d[IDX_UNDEF]) |-> (syn_d == '0));
  assert_syndrome_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_d[IDX_T2_A64] || res_d[IDX_T2_HYP] || res_d[IDX_T3]) |-> (syn_d == TRAP_EC));
  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(res_d) == 1);
endmodule

// File: tb/dbg_trap_arbiter_bench.sv
module dbg_trap_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] el;
  logic       el2_pres, el3_pres, el2_en, el2_a64, el3_a64;
  logic       el2_tacc, el2_texc, el3_tacc, prio, sddu;
  logic [4:0] result;
  logic [5:0] syn;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_trap_arbiter u_dbg_trap_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .el_i(el),
    .el2_present_i(el2_pres), .el3_present_i(el3_pres), .el2_enable_i(el2_en),
    .el2_aa64_i(el2_a64), .el3_aa64_i(el3_a64),
    .el2_trap_acc_i(el2_tacc), .el2_trap_exc_i(el2_texc), .el3_trap_acc_i(el3_tacc),
    .sdd_undef_prio_i(prio), .sdd_undef_i(sddu),
    .result_o(result), .syndrome_o(syn)
  );

  task automatic check(input string req, input logic [4:0] er, input logic [5:0] es);
    checks++;
    if (result !== er || syn !== es) begin
      errors++;
      $display("FAIL %s: result=%b syndrome=%h expected result=%b syndrome=%h",
               req, result, syn, er, es);
    end
  endtask

  task automatic apply(input logic [11:0] v);
    {el, el2_pres, el3_pres, el2_en, el2_a64, el3_a64,
     el2_tacc, el2_texc, el3_tacc, prio, sddu} = v;
  endtask

  // behavioural model; returns expected result and the requirement that decides it
  task automatic model(output logic [4:0] r, output string req);
    logic l3arm, l2on;
    l3arm = el3_pres && el3_a64 && el3_tacc;
    l2on  = el2_pres && el2_en && (el2_tacc || el2_texc);
    if (el == 2'd0) begin r = 5'b00010; req = "R1"; end
    else if (el == 2'd3) begin r = 5'b00001; req = "R2"; end
    else if (l3arm && prio) begin r = 5'b00010; req = "R3"; end
    else if (el == 2'd1 && l2on && el2_a64) begin r = 5'b00100; req = "R4"; end
    else if (el == 2'd1 && l2on && !el2_a64) begin r = 5'b01000; req = "R5"; end
    else if (l3arm) begin r = sddu ? 5'b00010 : 5'b10000; req = "R6"; end
    else begin r = 5'b00001; req = (el == 2'd2) ? "R7" : "R6"; end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: result=%b syndrome=%h expected completion", result, syn);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] er;
    logic [5:0] es;
    string      req;
    apply(12'h000);
    #12;
    check("R10 reset", 5'b00010, 6'h00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 4096; v++) begin
      @(negedge clk);
      apply(12'(v));
      @(posedge clk);
      #1;
      model(er, req);
      es = (er[2] || er[3] || er[4]) ? 6'h05 : 6'h00;
      check(req, er, es);
      check("R9 onehot", ($countones(result) == 1) ? result : 5'b00000, es);
    end
    // R10: a change before the edge must not reach the output
    @(negedge clk);
    apply({2'd3, 10'b0});
    @(posedge clk);
    #1;
    check("R10 latency", 5'b00001, 6'h00);
    @(negedge clk);
    apply({2'd0, 10'b0});
    #1;
    check("R10 hold", 5'b00001, 6'h00);
    @(posedge clk);
    #1;
    check("R10 update", 5'b00010, 6'h00);
    // R8 spot check on a level-3 trap
    @(negedge clk);
    apply({2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
    @(posedge clk);
    #1;
    check("R8 syndrome", 5'b10000, 6'h05);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule